// File: doc/BRIEF.md
# Exclusive/Inclusive Last-Level Line Coherence Controller

This block makes the coherence decision for one access to a last-level cache line. Each request carries a mode bit. In exclusive mode the cache holds a line only after an inner level writes it back, and a demand read hands the line up and drops it. In inclusive mode the line follows the usual four-state protocol (I, S, E, M), and writebacks stay in place. Two further flags change the decision. The inner-copy flag means an inner level already has the data, so no memory fetch is needed. The prefetch flag keeps an exclusive-mode line resident in E instead of dropping it.

For each request the block reports three things: whether memory (the parent) must be accessed, and with which read kind; whether the line state array is written and with what value; and the cycle at which the response is ready. It also keeps running counts of clean writebacks, dirty writebacks and writebacks taken in exclusive mode. Replacement, data storage and probing of inner levels are handled elsewhere. The caller supplies the current line state, a flag saying no line was allocated, the parent's latency and whether the parent grants exclusivity.

Top module: `llc_line_ctrl`

## Requirements
- R1: After reset, resp_valid, fetch_valid, state_we and illegal are 0, and all three counters are 0.
- R2: Every request sampled with req_valid high produces exactly one response cycle, with resp_valid high on the cycle after sampling. fetch_kind equals the request kind whenever fetch_valid is high. Kinds are encoded as GETS=0, GETX=1, PUTS=2, PUTX=3.
- R3: In exclusive mode with no_line set, GETS and GETX are legal. They fetch only if inner_copy is clear, and state_we stays 0. A PUTS or PUTX with no_line set is illegal.
- R4: In exclusive mode with an allocated line, PUTS and PUTX never fetch. Without inner_copy they write E=2 (for PUTS) or M=3 (for PUTX). With inner_copy set, state_we is 0. States are encoded as I=0, S=1, E=2, M=3.
- R5: In exclusive mode, GETS fetches only when the line is I and inner_copy is clear. GETX fetches only when the line is I or S and inner_copy is clear. E and M are hits.
- R6: After any exclusive-mode GETS or GETX on an allocated line, the line is written to I. If prefetch is set, it is written to E instead.
- R7: In inclusive mode, a GETS on I with inner_copy set writes S and does not fetch. A GETS on I without inner_copy fetches and writes E if parent_excl is set, otherwise S. A GETS on any other state keeps that state.
- R8: In inclusive mode, GETX always writes M. It fetches only from I or S without inner_copy, so E becomes M silently.
- R9: In inclusive mode, PUTS on a valid line keeps the state, and PUTS on I is illegal. PUTX on E or M writes M, and PUTX on I or S is illegal. Any inclusive-mode request with no_line set is illegal.
- R10: An illegal request raises illegal and makes no fetch, no state write and no counter change.
- R11: resp_cycle equals base_cycle plus parent_lat plus the round-trip parameter when fetch_valid is high. Otherwise it equals base_cycle.
- R12: Each legal PUTS increments cnt_puts by one and each legal PUTX increments cnt_putx by one, in either mode. cnt_exwb also increments by one for each legal PUT taken in exclusive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | GETS=0, GETX=1, PUTS=2, PUTX=3 |
| excl_mode | input | 1 | 1 = exclusive handling for this request |
| inner_copy | input | 1 | An inner level holds the data |
| prefetch | input | 1 | Request is a prefetch |
| no_line | input | 1 | No line was allocated for the request |
| line_state | input | 2 | Current line state (I=0, S=1, E=2, M=3) |
| parent_excl | input | 1 | Parent grants exclusivity on an inclusive GETS fill |
| base_cycle | input | CW | Cycle at which the lookup finished |
| parent_lat | input | LW | Latency of the parent access |
| resp_valid | output | 1 | Decision valid |
| fetch_valid | output | 1 | Parent access required |
| fetch_kind | output | 2 | Kind sent to the parent |
| state_we | output | 1 | Write the line state array |
| state_next | output | 2 | State to write |
| resp_cycle | output | CW | Response-ready cycle |
| illegal | output | 1 | Request not allowed in current state/mode |
| cnt_puts | output | NW | Clean writeback count |
| cnt_putx | output | NW | Dirty writeback count |
| cnt_exwb | output | NW | Exclusive-mode writeback count |

## Verification
The hardest situations to reach are the rarely combined flag settings: exclusive-mode requests with no allocated line, prefetches that must keep a line in E, and inner-copy writebacks that must leave the state array untouched. Uniform random values for every input would reach these only occasionally and would mostly produce illegal inclusive writebacks. The stimulus therefore weights the mode, inner-copy, prefetch and no-line bits separately. It also adds a directed sweep over every request kind, every state and both modes, with the inner-copy flag both set and clear, so that every row of the decision table is reached at least once.

// File: rtl/llc_line_pkg.sv
package llc_line_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    RQ_GETS = 2'd0,
    RQ_GETX = 2'd1,
    RQ_PUTS = 2'd2,
    RQ_PUTX = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic     legal;
    logic     fetch;
    logic     we;
    line_st_e nxt;
    logic     is_puts;
    logic     is_putx;
    logic     is_exwb;
  } decision_t;

  localparam int unsigned NUM_CNT = 3;

  function automatic logic is_get(req_kind_e k);
    return (k == RQ_GETS) || (k == RQ_GETX);
  endfunction

  function automatic logic needs_fill(req_kind_e k, line_st_e s);
    if (k == RQ_GETS) return s == ST_I;
    return (s == ST_I) || (s == ST_S);
  endfunction

endpackage

// File: rtl/llc_excl_decide.sv
module llc_excl_decide
  import llc_line_pkg::*;
(
  input  req_kind_e kind,
  input  line_st_e  cur,
  input  logic      inner,
  input  logic      pf,
  input  logic      noline,
  output decision_t d
);
  always_comb begin
    d = '0;
    d.nxt = ST_I;
    if (noline) begin
      // scratch state only: array untouched
      if (is_get(kind)) begin
        d.legal = 1'b1;
        d.fetch = !inner;
      end
    end else begin
      unique case (kind)
        RQ_PUTS: begin
          d.legal   = 1'b1;
          d.is_puts = 1'b1;
          d.is_exwb = 1'b1;
          d.we      = !inner;
          d.nxt     = inner ? cur : ST_E;
        end
        RQ_PUTX: begin
          d.legal   = 1'b1;
          d.is_putx = 1'b1;
          d.is_exwb = 1'b1;
          d.we      = !inner;
          d.nxt     = inner ? cur : ST_M;
        end
        default: begin
          d.legal = 1'b1;
          d.fetch = needs_fill(kind, cur) && !inner;
          d.we    = 1'b1;
          d.nxt   = pf ? ST_E : ST_I;
        end
      endcase
    end
  end
endmodule

// File: rtl/llc_incl_decide.sv
module llc_incl_decide
  import llc_line_pkg::*;
(
  input  req_kind_e kind,
  input  line_st_e  cur,
  input  logic      inner,
  input  logic      pexcl,
  input  logic      noline,
  output decision_t d
);
  always_comb begin
    d = '0;
    d.nxt = cur;
    if (!noline) begin
      unique case (kind)
        RQ_GETS: begin
          d.legal = 1'b1;
          d.we    = 1'b1;
          if (cur == ST_I) begin
            d.fetch = !inner;
            d.nxt   = (!inner && pexcl) ? ST_E : ST_S;
          end
        end
        RQ_GETX: begin
          d.legal = 1'b1;
          d.we    = 1'b1;
          d.fetch = needs_fill(kind, cur) && !inner;
          d.nxt   = ST_M;
        end
        RQ_PUTS: begin
          d.legal   = (cur != ST_I);
          d.we      = d.legal;
          d.is_puts = d.legal;
        end
        default: begin
          d.legal   = (cur == ST_E) || (cur == ST_M);
          d.we      = d.legal;
          d.is_putx = d.legal;
          d.nxt     = ST_M;
        end
      endcase
    end
  end
endmodule

// File: rtl/llc_wb_counters.sv
module llc_wb_counters
  import llc_line_pkg::*;
#(
  parameter int unsigned NW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CNT-1:0]          inc,
  output logic [NUM_CNT-1:0][NW-1:0]  cnt
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + NW'(1);
    end

    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] != $past(cnt[g])) |-> (cnt[g] == $past(cnt[g]) + NW'(1)));
  end

  // exclusive writeback always accompanies a clean or dirty writeback (R12)
  assert_exwb_paired_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inc[2] |-> (inc[0] || inc[1]));
endmodule

// File: rtl/llc_line_ctrl.sv
module llc_line_ctrl
  import llc_line_pkg::*;
#(
  parameter int unsigned CW  = 32,
  parameter int unsigned LW  = 12,
  parameter int unsigned NW  = 16,
  parameter int unsigned RTT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          excl_mode,
  input  logic          inner_copy,
  input  logic          prefetch,
  input  logic          no_line,
  input  logic [1:0]    line_state,
  input  logic          parent_excl,
  input  logic [CW-1:0] base_cycle,
  input  logic [LW-1:0] parent_lat,
  output logic          resp_valid,
  output logic          fetch_valid,
  output logic [1:0]    fetch_kind,
  output logic          state_we,
  output logic [1:0]    state_next,
  output logic [CW-1:0] resp_cycle,
  output logic          illegal,
  output logic [NW-1:0] cnt_puts,
  output logic [NW-1:0] cnt_putx,
  output logic [NW-1:0] cnt_exwb
);
  localparam logic [CW-1:0] RTT_C = CW'(RTT);

  function automatic logic [CW-1:0] lat_of(logic [CW-1:0] base, logic [LW-1:0] plat, logic go);
    return go ? base + CW'(plat) + RTT_C : base;
  endfunction

  req_kind_e kind_in;
  line_st_e  cur_in;
  assign kind_in = req_kind_e'(req_kind);
  assign cur_in  = line_st_e'(line_state);

  decision_t d_ex, d_in, d_sel;

  llc_excl_decide u_ex (
    .kind(kind_in), .cur(cur_in), .inner(inner_copy), .pf(prefetch),
    .noline(no_line), .d(d_ex)
  );

  llc_incl_decide u_in (
    .kind(kind_in), .cur(cur_in), .inner(inner_copy), .pexcl(parent_excl),
    .noline(no_line), .d(d_in)
  );

  assign d_sel = excl_mode ? d_ex : d_in;

  // named events for checking
  logic ev_fetch, ev_write, ev_bad;
  assign ev_fetch = req_valid && d_sel.legal && d_sel.fetch;
  assign ev_write = req_valid && d_sel.legal && d_sel.we;
  assign ev_bad   = req_valid && !d_sel.legal;

  logic [NUM_CNT-1:0]         cnt_inc;
  logic [NUM_CNT-1:0][NW-1:0] cnt_all;
  assign cnt_inc = {req_valid && d_sel.legal && d_sel.is_exwb,
                    req_valid && d_sel.legal && d_sel.is_putx,
                    req_valid && d_sel.legal && d_sel.is_puts};

  llc_wb_counters #(.NW(NW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .cnt(cnt_all)
  );
  assign cnt_puts = cnt_all[0];
  assign cnt_putx = cnt_all[1];
  assign cnt_exwb = cnt_all[2];

  // held copies of the request qualifiers for the transaction
  logic          h_excl, h_inner, h_pf, h_noline;
  req_kind_e     h_kind;
  logic [CW-1:0] h_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      fetch_valid <= 1'b0;
      fetch_kind  <= 2'd0;
      state_we    <= 1'b0;
      state_next  <= 2'd0;
      resp_cycle  <= '0;
      illegal     <= 1'b0;
      h_excl      <= 1'b0;
      h_inner     <= 1'b0;
      h_pf        <= 1'b0;
      h_noline    <= 1'b0;
      h_kind      <= RQ_GETS;
      h_base      <= '0;
    end else begin
      resp_valid  <= req_valid;
      fetch_valid <= ev_fetch;
      fetch_kind  <= req_kind;
      state_we    <= ev_write;
      state_next  <= d_sel.nxt;
      resp_cycle  <= lat_of(base_cycle, parent_lat, ev_fetch);
      illegal     <= ev_bad;
      if (req_valid) begin
        h_excl   <= excl_mode;
        h_inner  <= inner_copy;
        h_pf     <= prefetch;
        h_noline <= no_line;
        h_kind   <= kind_in;
        h_base   <= base_cycle;
      end
    end
  end

  assert_inner_blocks_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && fetch_valid) |-> !h_inner);

  assert_noline_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && h_noline) |-> !state_we);

  assert_excl_get_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && h_excl && !h_noline && is_get(h_kind) && !h_pf)
      |-> (state_we && state_next == ST_I));

  assert_incl_getx_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !h_excl && h_kind == RQ_GETX && !illegal) |-> (state_next == ST_M));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!fetch_valid && !state_we));

  assert_nofetch_base_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !fetch_valid) |-> (resp_cycle == h_base));

  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !resp_valid);

endmodule

// File: tb/llc_line_ctrl_tb.sv
`timescale 1ns/1ps
module llc_line_ctrl_tb;
  localparam int CW = 32;
  localparam int LW = 12;
  localparam int NW = 16;
  localparam int RT = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic          excl_mode, inner_copy, prefetch, no_line, parent_excl;
  logic [1:0]    line_state;
  logic [CW-1:0] base_cycle;
  logic [LW-1:0] parent_lat;
  logic          resp_valid, fetch_valid, state_we, illegal;
  logic [1:0]    fetch_kind, state_next;
  logic [CW-1:0] resp_cycle;
  logic [NW-1:0] cnt_puts, cnt_putx, cnt_exwb;

  always #4 clk = ~clk;

  llc_line_ctrl #(.CW(CW), .LW(LW), .NW(NW), .RTT(RT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .excl_mode(excl_mode), .inner_copy(inner_copy), .prefetch(prefetch),
    .no_line(no_line), .line_state(line_state), .parent_excl(parent_excl),
    .base_cycle(base_cycle), .parent_lat(parent_lat), .resp_valid(resp_valid),
    .fetch_valid(fetch_valid), .fetch_kind(fetch_kind), .state_we(state_we),
    .state_next(state_next), .resp_cycle(resp_cycle), .illegal(illegal),
    .cnt_puts(cnt_puts), .cnt_putx(cnt_putx), .cnt_exwb(cnt_exwb)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [NW-1:0] e_puts = '0, e_putx = '0, e_exwb = '0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected outcome, from the requirement table
  typedef struct { bit legal; bit fet; bit we; int nx; } exp_t;

  function automatic exp_t model(int k, bit ex, bit inr, bit pf, bit nl, int s, bit pe);
    exp_t e; e.legal = 0; e.fet = 0; e.we = 0; e.nx = 0;
    if (ex) begin
      if (nl) begin
        if (k < 2) begin e.legal = 1; e.fet = !inr; end
      end else if (k >= 2) begin
        e.legal = 1; e.we = !inr; e.nx = (k == 2) ? 2 : 3;
      end else begin
        e.legal = 1; e.we = 1; e.nx = pf ? 2 : 0;
        e.fet = !inr && ((s == 0) || (k == 1 && s == 1));
      end
    end else if (!nl) begin
      case (k)
        0: begin e.legal = 1; e.we = 1;
             if (s == 0) begin e.fet = !inr; e.nx = (!inr && pe) ? 2 : 1; end else e.nx = s; end
        1: begin e.legal = 1; e.we = 1; e.nx = 3; e.fet = !inr && s < 2; end
        2: begin e.legal = (s != 0); e.we = e.legal; e.nx = s; end
        default: begin e.legal = (s >= 2); e.we = e.legal; e.nx = 3; end
      endcase
    end
    return e;
  endfunction

  task automatic run(input int k, input bit ex, input bit inr, input bit pf, input bit nl,
                     input int s, input bit pe, input int base, input int pl, input string tag);
    exp_t e;
    logic [CW-1:0] ecyc;
    @(negedge clk);
    req_valid = 1; req_kind = 2'(k); excl_mode = ex; inner_copy = inr; prefetch = pf;
    no_line = nl; line_state = 2'(s); parent_excl = pe; base_cycle = CW'(base); parent_lat = LW'(pl);
    e = model(k, ex, inr, pf, nl, s, pe);
    if (e.legal && k == 2) e_puts++;
    if (e.legal && k == 3) e_putx++;
    if (e.legal && k >= 2 && ex) e_exwb++;
    ecyc = e.fet ? CW'(base) + CW'(pl) + CW'(RT) : CW'(base);
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid == 1, {tag, " R2 resp_valid"}, resp_valid, 1);
    chk(fetch_valid == e.fet, {tag, " fetch"}, fetch_valid, e.fet);
    if (e.fet) chk(fetch_kind == 2'(k), {tag, " R2 fetch_kind"}, fetch_kind, k);
    chk(state_we == e.we, {tag, " state_we"}, state_we, e.we);
    if (e.we) chk(state_next == 2'(e.nx), {tag, " state_next"}, state_next, e.nx);
    chk(illegal == !e.legal, {tag, " R10 illegal"}, illegal, !e.legal);
    chk(resp_cycle == ecyc, {tag, " R11 resp_cycle"}, resp_cycle, ecyc);
    chk(cnt_puts == e_puts, {tag, " R12 cnt_puts"}, cnt_puts, e_puts);
    chk(cnt_putx == e_putx, {tag, " R12 cnt_putx"}, cnt_putx, e_putx);
    chk(cnt_exwb == e_exwb, {tag, " R12 cnt_exwb"}, cnt_exwb, e_exwb);
  endtask

  function automatic string tag_of(int k, bit ex, bit nl);
    if (ex && nl) return "R3";
    if (ex && k >= 2) return "R4";
    if (ex) return "R5 R6";
    if (k == 0) return "R7";
    if (k == 1) return "R8";
    return "R9";
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1C0FFEE);
    rst_n = 0; req_valid = 0; req_kind = 0; excl_mode = 0; inner_copy = 0; prefetch = 0;
    no_line = 0; line_state = 0; parent_excl = 0; base_cycle = 0; parent_lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(resp_valid == 0, "R1 resp_valid", resp_valid, 0);
    chk(fetch_valid == 0 && state_we == 0 && illegal == 0, "R1 flags", {fetch_valid, state_we, illegal}, 0);
    chk(cnt_puts == 0 && cnt_putx == 0 && cnt_exwb == 0, "R1 counters", cnt_puts + cnt_putx + cnt_exwb, 0);

    // directed corners
    run(0, 1, 0, 0, 1, 0, 0, 100, 40, "R3 excl noline GETS fetch");
    run(1, 1, 1, 0, 1, 0, 0, 100, 40, "R3 excl noline GETX inner");
    run(2, 1, 0, 0, 1, 0, 0, 100, 40, "R3 excl noline PUTS illegal");
    run(2, 1, 0, 0, 0, 0, 0, 200, 9, "R4 excl PUTS fill E");
    run(3, 1, 0, 0, 0, 0, 0, 200, 9, "R4 excl PUTX fill M");
    run(3, 1, 1, 0, 0, 1, 0, 200, 9, "R4 excl PUTX inner keep");
    run(1, 1, 0, 0, 0, 1, 0, 300, 55, "R5 excl GETX on S fetch");
    run(1, 1, 0, 0, 0, 2, 0, 300, 55, "R5 excl GETX on E hit");
    run(0, 1, 0, 1, 0, 0, 0, 300, 55, "R6 excl GETS prefetch E");
    run(0, 1, 0, 0, 0, 3, 0, 300, 55, "R6 excl GETS drop");
    run(0, 0, 1, 0, 0, 0, 0, 400, 70, "R7 incl GETS inner S");
    run(0, 0, 0, 0, 0, 0, 1, 400, 70, "R7 incl GETS parent E");
    run(1, 0, 1, 0, 0, 1, 0, 400, 70, "R8 incl GETX S inner");
    run(1, 0, 0, 0, 0, 2, 0, 400, 70, "R8 incl GETX E silent");
    run(2, 0, 0, 0, 0, 0, 0, 500, 3, "R9 incl PUTS on I");
    run(3, 0, 0, 0, 0, 1, 0, 500, 3, "R9 incl PUTX on S");
    run(3, 0, 0, 0, 0, 2, 0, 500, 3, "R9 incl PUTX E to M");
    run(0, 0, 0, 0, 1, 0, 0, 500, 3, "R9 incl noline");

    // sweep of the decision table
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int m = 0; m < 4; m++)
          run(k, m[0], m[1], 0, 0, s, 0, 1000 + s, 20 + k, {tag_of(k, m[0], 0), " sweep"});

    // weighted random
    for (int i = 0; i < 600; i++) begin
      int k, s, base, pl;
      bit ex, inr, pf, nl, pe;
      k = int'($urandom_range(3)); s = int'($urandom_range(3));
      ex = ($urandom_range(99) < 55); inr = ($urandom_range(99) < 30);
      pf = ($urandom_range(99) < 25); nl = ($urandom_range(99) < 15);
      pe = $urandom_range(1) == 1;
      base = int'($urandom_range(100000)); pl = int'($urandom_range(4095));
      run(k, ex, inr, pf, nl, s, pe, base, pl, {tag_of(k, ex, nl), " random"});
    end

    @(negedge clk);
    chk(resp_valid == 0, "R2 idle after last", resp_valid, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule